// File: doc/BRIEF.md
# Shared-Counter Multichannel PWM Timer

This block is a register-mapped PWM timer. A single 16-bit up-counter, advanced through a power-of-two prescaler, sets the period for every channel. Each channel keeps its own compare value and its own output level selection, so all outputs share one period while each has its own duty and polarity. Only edge-aligned PWM is produced: an output changes level when the shared counter crosses the channel's compare value and again when the counter wraps.

Software programs the block through a simple word-addressed register port: a write strobe with address and data, and read data that is returned one clock after the address is presented. A read-only parameter register reports how many channels are built. While the counter runs, new modulo and compare values are held in shadow registers and take effect together at the next wrap, so a period is never cut short or stretched by a write part way through it. While the counter is stopped, the same writes take effect at once.

Top module: `shared_pwm_timer`

## Requirements
- R1: The register at offset 0x04 returns the channel count in bits [7:0] and ignores writes; after reset the control register reads 0, the counter reads 0, the modulo reads 0xFFFF, every channel control reads 0 and every PWM output is low.
- R2: The timer control register at offset 0x10 holds the prescale code in bits [2:0], the clock mode in bits [4:3] and a center-align select in bit 5; all six bits read back as written, only clock mode 01 runs the counter (00, 10 and 11 leave it stopped), and bit 5 does not alter the waveform.
- R3: The counter at offset 0x14 is read-only; while running it steps by one every 2^PS clocks, and while stopped it holds its value and the prescaler phase returns to zero.
- R4: On the step taken with the counter at or above the active modulo, the counter returns to 0, so the period is (MOD+1)*2^PS clocks.
- R5: A write to the modulo register at offset 0x18 while the counter is stopped becomes the active modulo immediately.
- R6: While the counter runs, writes to the modulo and to the channel compare values are held and become active only at the next wrap; reading either register returns the last value written.
- R7: Channel n has its control register at 0x20+8n and its compare value at 0x24+8n; control bit 7 is the compare flag, bit 5 and bit 4 are mode-select bits, bits [3:2] are the level select; the output is driven only when bit 5 is 1, bit 4 is 0 and the level select is 10 or 01.
- R8: With level select 10 the output is high while the counter is below the compare value, giving CV*2^PS high clocks per period.
- R9: With level select 01 the output is the inverse: low while the counter is below the compare value.
- R10: With level select 10, a compare value of 0 gives a constant low output and a compare value above the modulo gives a constant high output.
- R11: A channel with level select 00, or not in edge-aligned mode, drives its output low whatever its compare value.
- R12: The compare flag is set in any clock in which the counter runs and equals the channel's active compare value; writing 1 to bit 7 clears it, writing 0 leaves it unchanged, and a set in the same clock as a clear wins.
- R13: Read data appears on the clock after the address, and each PWM output is registered, trailing the counter by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for the address of the previous clock |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The bench rewrites the modulo shortly after a wrap while the counter runs and times the period that contains the write; a design that applied the value at once would end that period after about ten clocks instead of fifty. It also stops the counter, raises the modulo far above the held count and restarts, which tells an immediate update (a long first period) from one wrongly deferred to the wrap (a short one). The compare extremes of 0 and above the modulo, the disabled and non-edge modes, the prescaled timing and the write-one-to-clear flag are each checked, catching off-by-one duty counts, outputs that leak through when a channel is off, and flags cleared by a zero write.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int PS_W = 3;

  localparam logic [7:0] OFS_PARAM   = 8'h04;
  localparam logic [7:0] OFS_CTRL    = 8'h10;
  localparam logic [7:0] OFS_COUNT   = 8'h14;
  localparam logic [7:0] OFS_MOD     = 8'h18;
  localparam logic [7:0] OFS_CH_BASE = 8'h20;
  localparam int         CH_STRIDE   = 8;
  localparam int         CH_VAL_OFS  = 4;

  typedef enum logic [1:0] {
    CLK_STOP = 2'b00,
    CLK_RUN  = 2'b01,
    CLK_RS2  = 2'b10,
    CLK_RS3  = 2'b11
  } clk_mode_e;

  typedef enum logic [1:0] {
    LVL_OFF  = 2'b00,
    LVL_INV  = 2'b01,
    LVL_NORM = 2'b10,
    LVL_RSV  = 2'b11
  } level_e;

  typedef struct packed {
    logic            center;
    clk_mode_e       mode;
    logic [PS_W-1:0] ps;
  } tmr_ctrl_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  localparam int PRE_W = (1 << PS_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  // Low PS bits all ones marks the last clock of a 2^PS group.
  always_comb mask = PRE_W'((32'd1 << ps) - 32'd1);

  assign tick = run && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             mod_we,
  input  logic [CNT_W-1:0] mod_wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] mod_act,
  output logic [CNT_W-1:0] mod_buf,
  output logic             wrap
);
  assign wrap = tick && (cnt_q >= mod_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      mod_act <= '1;
      mod_buf <= '1;
    end else begin
      if (mod_we) begin
        mod_buf <= mod_wdata;
        if (!run) mod_act <= mod_wdata;
      end
      if (tick) begin
        if (wrap) begin
          cnt_q   <= '0;
          mod_act <= mod_buf;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ctrl_we,
  input  logic             flag_clr_bit,
  input  logic             msb_in,
  input  logic             msa_in,
  input  logic [1:0]       lvl_in,
  input  logic             val_we,
  input  logic [CNT_W-1:0] val_wdata,
  output logic [7:0]       ctrl_rd,
  output logic [CNT_W-1:0] val_rd,
  output logic             en,
  output logic             pwm
);
  logic             msb_q, msa_q, flag_q;
  level_e           lvl_q;
  logic [CNT_W-1:0] cv_buf, cv_act;
  logic             below;

  assign en      = msb_q && !msa_q && (lvl_q == LVL_NORM || lvl_q == LVL_INV);
  assign below   = cnt < cv_act;
  assign ctrl_rd = {flag_q, 1'b0, msb_q, msa_q, lvl_q, 2'b00};
  assign val_rd  = cv_buf;

  always_ff @(posedge clk) begin
    if (rst) begin
      msb_q <= 1'b0;
      msa_q <= 1'b0;
      lvl_q <= LVL_OFF;
    end else if (ctrl_we) begin
      msb_q <= msb_in;
      msa_q <= msa_in;
      lvl_q <= level_e'(lvl_in);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                               flag_q <= 1'b0;
    else if (run && cnt == cv_act)         flag_q <= 1'b1;
    else if (ctrl_we && flag_clr_bit)      flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cv_buf <= '0;
      cv_act <= '0;
    end else begin
      if (val_we) begin
        cv_buf <= val_wdata;
        if (!run) cv_act <= val_wdata;
      end
      if (wrap) cv_act <= cv_buf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en)            pwm <= 1'b0;
    else if (lvl_q == LVL_NORM) pwm <= below;
    else                        pwm <= !below;
  end
endmodule

// File: rtl/shared_pwm_timer.sv
module shared_pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int CTRL_W = $bits(tmr_ctrl_t);

  tmr_ctrl_t        ctrl_q;
  logic             run, tick, wrap;
  logic [CNT_W-1:0] cnt_q, mod_act, mod_buf;
  logic [CNT_W-1:0] rd_d;
  logic [NUM_CH-1:0] ch_en;
  logic [7:0]       ch_ctrl_rd [NUM_CH];
  logic [CNT_W-1:0] ch_val_rd  [NUM_CH];

  logic hit_ctrl, hit_mod;
  assign hit_ctrl = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_mod  = bus_we && (bus_addr == ADDR_W'(OFS_MOD));
  assign run      = (ctrl_q.mode == CLK_RUN);

  always_ff @(posedge clk) begin
    if (rst)           ctrl_q <= '0;
    else if (hit_ctrl) ctrl_q <= tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  pwm_prescaler #(.PS_W(PS_W)) u_pre (
    .clk (clk),
    .rst (rst),
    .run (run),
    .ps  (ctrl_q.ps),
    .tick(tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .tick     (tick),
    .mod_we   (hit_mod),
    .mod_wdata(bus_wdata),
    .cnt_q    (cnt_q),
    .mod_act  (mod_act),
    .mod_buf  (mod_buf),
    .wrap     (wrap)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(int'(OFS_CH_BASE) + CH_STRIDE * g);
    localparam logic [ADDR_W-1:0] A_VAL  = ADDR_W'(int'(OFS_CH_BASE) + CH_STRIDE * g + CH_VAL_OFS);

    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk         (clk),
      .rst         (rst),
      .run         (run),
      .wrap        (wrap),
      .cnt         (cnt_q),
      .ctrl_we     (bus_we && bus_addr == A_CTRL),
      .flag_clr_bit(bus_wdata[7]),
      .msb_in      (bus_wdata[5]),
      .msa_in      (bus_wdata[4]),
      .lvl_in      (bus_wdata[3:2]),
      .val_we      (bus_we && bus_addr == A_VAL),
      .val_wdata   (bus_wdata),
      .ctrl_rd     (ch_ctrl_rd[g]),
      .val_rd      (ch_val_rd[g]),
      .en          (ch_en[g]),
      .pwm         (pwm_out[g])
    );
  end

  always_comb begin
    rd_d = '0;
    if (bus_addr == ADDR_W'(OFS_PARAM)) rd_d[7:0] = 8'(NUM_CH);
    if (bus_addr == ADDR_W'(OFS_CTRL))  rd_d[CTRL_W-1:0] = ctrl_q;
    if (bus_addr == ADDR_W'(OFS_COUNT)) rd_d = cnt_q;
    if (bus_addr == ADDR_W'(OFS_MOD))   rd_d = mod_buf;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(int'(OFS_CH_BASE) + CH_STRIDE * i))
        rd_d[7:0] = ch_ctrl_rd[i];
      if (bus_addr == ADDR_W'(int'(OFS_CH_BASE) + CH_STRIDE * i + CH_VAL_OFS))
        rd_d = ch_val_rd[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end
endmodule

// File: rtl/pwm_timer_checker.sv
module pwm_timer_checker #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              tick,
  input logic              wrap,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  mod_act,
  input logic [NUM_CH-1:0] ch_en,
  input logic [NUM_CH-1:0] pwm_out
);
  // R3: stopped counter keeps its value
  assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == $past(cnt)));

  // R3: a non-wrapping step adds exactly one
  assert_step_by_one_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && !wrap) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R4: a wrap step lands on zero
  assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));

  // R6: a running counter changes its modulo only at a wrap
  assert_mod_held_while_running_R6: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap) |=> (mod_act == $past(mod_act)));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R11: a disabled channel drives low
    assert_disabled_low_R11: assert property (@(posedge clk) disable iff (rst)
      !ch_en[g] |=> !pwm_out[g]);
  end
endmodule

bind shared_pwm_timer pwm_timer_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_checker (
  .clk    (clk),
  .rst    (rst),
  .run    (run),
  .tick   (tick),
  .wrap   (wrap),
  .cnt    (cnt_q),
  .mod_act(mod_act),
  .ch_en  (ch_en),
  .pwm_out(pwm_out)
);

// File: tb/tb_shared_pwm_timer.sv
module tb_shared_pwm_timer;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [NCH-1:0] pwm_out;

  int checks = 0;
  int errors = 0;

  localparam logic [7:0] A_PARAM = 8'h04, A_CTRL = 8'h10, A_CNT = 8'h14, A_MOD = 8'h18;
  localparam logic [7:0] A_C0 = 8'h20, A_V0 = 8'h24, A_C1 = 8'h28, A_V1 = 8'h2C, A_C2 = 8'h30;

  always #2 clk = ~clk;

  shared_pwm_timer #(.NUM_CH(NCH), .CNT_W(16), .ADDR_W(8)) dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = int'(bus_rdata);
  endtask

  task automatic wait_level(input int ch, input logic v);
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (pwm_out[ch] == v) break;
    end
  endtask

  task automatic measure(input int ch, output int hi, output int per);
    logic prev;
    wait_level(ch, 1'b0);
    wait_level(ch, 1'b1);
    hi = 0; per = 0;
    do begin
      hi += int'(pwm_out[ch]);
      per++;
      prev = pwm_out[ch];
      @(negedge clk);
    end while (!(prev == 1'b0 && pwm_out[ch] == 1'b1) && per < 5000);
  endtask

  task automatic count_high(input int ch, input int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      hi += int'(pwm_out[ch]);
    end
  endtask

  task automatic t_reset;
    int d;
    rd(A_PARAM, d); chk("R1 param count", d, NCH);
    rd(A_CTRL, d);  chk("R1 ctrl reset", d, 0);
    rd(A_MOD, d);   chk("R1 mod reset", d, 16'hFFFF);
    rd(A_CNT, d);   chk("R13 R1 count reset", d, 0);
    rd(A_C0, d);    chk("R1 ch0 ctrl reset", d, 0);
    chk("R1 outputs low", int'(pwm_out), 0);
  endtask

  task automatic t_basic;
    int hi, per;
    wr(A_MOD, 16'd9);
    wr(A_V0, 16'd3); wr(A_C0, 16'h28);
    wr(A_V1, 16'd3); wr(A_C1, 16'h24);
    wr(A_CTRL, 16'h08);
    measure(0, hi, per);
    chk("R4 period ps0", per, 10);
    chk("R8 normal high", hi, 3);
    measure(1, hi, per);
    chk("R9 inverted period", per, 10);
    chk("R9 inverted high", hi, 7);
    count_high(2, 30, hi);
    chk("R11 unconfigured channel low", hi, 0);
  endtask

  task automatic t_prescale;
    int hi, per;
    wr(A_CTRL, 16'h00);
    wr(A_CTRL, 16'h0A);
    measure(0, hi, per);
    chk("R3 prescaled period", per, 40);
    chk("R8 prescaled high", hi, 12);
    wr(A_CTRL, 16'h00);
    wr(A_CTRL, 16'h08);
  endtask

  task automatic t_extremes;
    int hi;
    wr(A_V0, 16'd0);
    repeat (25) @(negedge clk);
    count_high(0, 40, hi);
    chk("R10 compare zero low", hi, 0);
    wr(A_V0, 16'd10);
    repeat (25) @(negedge clk);
    count_high(0, 40, hi);
    chk("R10 compare above modulo high", hi, 40);
    wr(A_V0, 16'd3);
    repeat (25) @(negedge clk);
  endtask

  task automatic t_disable;
    int hi, per;
    wr(A_C0, 16'h20);
    count_high(0, 40, hi);
    chk("R11 level 00 low", hi, 0);
    wr(A_C0, 16'h08);
    count_high(0, 40, hi);
    chk("R7 not edge mode low", hi, 0);
    wr(A_C0, 16'h38);
    count_high(0, 40, hi);
    chk("R7 mode bit4 set low", hi, 0);
    wr(A_C0, 16'h28);
    measure(0, hi, per);
    chk("R7 re-enabled high", hi, 3);
  endtask

  task automatic t_buffer;
    int hi, per, d;
    logic prev;
    wr(A_V0, 16'd5);
    wr(A_MOD, 16'd49);
    rd(A_MOD, d); chk("R6 modulo reads written", d, 49);
    measure(0, hi, per);
    chk("R6 new period after wrap", per, 50);
    chk("R6 compare loaded at wrap", hi, 5);
    wait_level(0, 1'b0);
    wait_level(0, 1'b1);
    bus_we = 1'b1; bus_addr = A_MOD; bus_wdata = 16'd9;
    per = 0;
    do begin
      per++;
      prev = pwm_out[0];
      @(negedge clk);
      bus_we = 1'b0;
    end while (!(prev == 1'b0 && pwm_out[0] == 1'b1) && per < 5000);
    chk("R6 period in progress kept", per, 50);
    measure(0, hi, per);
    chk("R6 short period after wrap", per, 10);
  endtask

  task automatic t_immediate;
    int hi, per, n;
    logic seen_low;
    wr(A_CTRL, 16'h00);
    wr(A_V0, 16'd3);
    wr(A_MOD, 16'd200);
    wr(A_CTRL, 16'h08);
    n = 0; seen_low = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      n++;
      if (pwm_out[0] == 1'b0) seen_low = 1'b1;
      else if (seen_low) break;
    end
    chk("R5 long first period", int'(n > 100 && n < 260), 1);
    measure(0, hi, per);
    chk("R5 immediate modulo period", per, 201);
    chk("R5 high with large modulo", hi, 3);
  endtask

  task automatic t_flag;
    int d;
    wr(A_CTRL, 16'h00);
    wr(A_MOD, 16'd9);
    wr(A_CTRL, 16'h08);
    repeat (30) @(negedge clk);
    rd(A_C0, d); chk("R12 flag set on match", d, 16'hA8);
    wr(A_CTRL, 16'h00);
    wr(A_C0, 16'h28);
    rd(A_C0, d); chk("R12 zero write keeps flag", d, 16'hA8);
    wr(A_C0, 16'hA8);
    rd(A_C0, d); chk("R12 one write clears flag", d, 16'h28);
    repeat (20) @(negedge clk);
    rd(A_C0, d); chk("R12 stopped no set", d, 16'h28);
  endtask

  task automatic t_hold;
    int a, b, d;
    rd(A_CNT, a);
    repeat (20) @(negedge clk);
    rd(A_CNT, b); chk("R3 counter holds stopped", b, a);
    wr(A_CTRL, 16'h18);
    rd(A_CTRL, d); chk("R2 ctrl readback mode 11", d, 16'h18);
    repeat (20) @(negedge clk);
    rd(A_CNT, b); chk("R2 mode 11 stopped", b, a);
    wr(A_CTRL, 16'h20);
    rd(A_CTRL, d); chk("R2 center bit readback", d, 16'h20);
    wr(A_CNT, 16'd5);
    rd(A_CNT, b); chk("R3 counter read-only", b, a);
    wr(A_PARAM, 16'd0);
    rd(A_PARAM, d); chk("R1 param ignores write", d, NCH);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_prescale();
    t_extremes();
    t_disable();
    t_buffer();
    t_immediate();
    t_flag();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1..: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule